// File: doc/BRIEF.md
# Dual-Mode Divider Configuration Loader

This block holds the programming of a clock synthesizer: a 9-bit feedback divide value, a 2-bit output divide code and two test bits. The divide values can come from dedicated parallel pins or from a three-wire serial port made of a serial clock, a serial data line and a load strobe. Each pin is brought into the fast system clock domain through a two-flop synchronizer. Edges are found by comparing each synchronized sample with the one before it.

Each load path is transparent while its control is at one level and holds its value once the control leaves that level. The parallel path follows the pins while the parallel-load input is low and keeps the last value once that input goes high. The serial path copies the shift register into the active values while the strobe is high, and keeps them once the strobe falls. A serial transfer replaces values that the parallel path has latched. When the test bits have been set serially, they choose the source of the test output. While the parallel path is in control, the test output is low.

Top module: `divcfg_loader`

## Requirements
- R1: While `rst_n` is low, `m_val`, `n_val`, `t_val` and the shift register are 0 and `test_sel` is 00. After reset the block is in parallel mode.
- R2: While `par_load` is low, `m_val` and `n_val` follow `par_m` and `par_n`. A pin change shows at the outputs within four system clocks.
- R3: After `par_load` rises, the outputs keep the last values they followed. Later changes on `par_m` and `par_n` have no effect while `par_load` stays high and no serial transfer occurs.
- R4: While `par_load` is high, each rising `ser_clk` shifts `ser_dat` into a 14-bit shift register. While `ser_strobe` is low, shifting leaves `m_val`, `n_val` and `t_val` unchanged.
- R5: The serial frame is sent MSB first in this order: T1, T0, a null slot, N1, N0, M8 down to M0. After 14 shifts, T sits in register bits [13:12], N in [10:9] and M in [8:0]. The null bit at [11] drives nothing.
- R6: While `par_load` and `ser_strobe` are both high, the active values track the shift register, including after every further rising `ser_clk`. After `ser_strobe` falls, the outputs hold.
- R7: A serial transfer replaces values latched by the parallel path. Driving `par_load` low again returns control to the pins.
- R8: `test_sel` equals `t_val` after a serial transfer and stays 00 for as long as the parallel path was the last to set the outputs.
- R9: `test_out` follows `test_sel`: 00 gives 0, 01 gives `ser_dat`, 10 gives `fb_clk` and 11 gives `syn_clk`.
- R10: Parallel loading leaves `t_val` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| par_load | input | 1 | Parallel path: transparent while low, holds while high |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 2 | Parallel output divide code |
| ser_clk | input | 1 | Serial shift clock; the rising edge is used |
| ser_dat | input | 1 | Serial data |
| ser_strobe | input | 1 | Serial load strobe: transparent while high |
| fb_clk | input | 1 | Feedback divider output, routed to the test output |
| syn_clk | input | 1 | Synthesized clock, routed to the test output |
| m_val | output | 9 | Active feedback divide value |
| n_val | output | 2 | Active output divide code |
| t_val | output | 2 | Active test bits |
| test_sel | output | 2 | Test output select; 00 in parallel mode |
| test_out | output | 1 | Test output |

## Verification
The parallel path is driven with several pin values in transparent mode, and then with pin changes after the latch, which shows following apart from holding. Serial frames are shifted with the strobe low and then pulsed. Different T, N and M contents and a set null bit show whether each field lands where it should and whether the null slot is ignored. With the strobe held high, single extra bits are shifted, and each one must reach the outputs at once; after the strobe falls, the same shifts must change nothing. Parallel and serial loads are then alternated, which shows which path wins and that the test bits survive a parallel reload.

// File: rtl/divcfg_loader.sv
module divcfg_loader #(
  parameter int MW = 9,
  parameter int NW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          par_load,
  input  logic [MW-1:0] par_m,
  input  logic [NW-1:0] par_n,
  input  logic          ser_clk,
  input  logic          ser_dat,
  input  logic          ser_strobe,
  input  logic          fb_clk,
  input  logic          syn_clk,
  output logic [MW-1:0] m_val,
  output logic [NW-1:0] n_val,
  output logic [1:0]    t_val,
  output logic [1:0]    test_sel,
  output logic          test_out
);
  localparam int FW = MW + NW + 3;
  localparam int IW = MW + NW + 4;

  logic [IW-1:0] raw, meta, syn;
  logic          pl_s, sclk_s, sdat_s, sld_s, sclk_p, par_mode;
  logic [MW-1:0] m_s;
  logic [NW-1:0] n_s;
  logic [FW-1:0] sr, sr_nx;

  assign raw = {par_load, ser_clk, ser_dat, ser_strobe, par_n, par_m};
  assign {pl_s, sclk_s, sdat_s, sld_s, n_s, m_s} = syn;

  assign sr_nx = (pl_s && sclk_s && !sclk_p) ? {sr[FW-2:0], sdat_s} : sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta     <= '0;
      syn      <= '0;
      sclk_p   <= 1'b0;
      sr       <= '0;
      m_val    <= '0;
      n_val    <= '0;
      t_val    <= '0;
      par_mode <= 1'b1;
    end else begin
      meta   <= raw;
      syn    <= meta;
      sclk_p <= sclk_s;
      sr     <= sr_nx;
      if (!pl_s) begin
        m_val    <= m_s;
        n_val    <= n_s;
        par_mode <= 1'b1;
      end else if (sld_s) begin
        m_val    <= sr_nx[MW-1:0];
        n_val    <= sr_nx[MW+NW-1:MW];
        t_val    <= sr_nx[FW-1:FW-2];
        par_mode <= 1'b0;
      end
    end
  end

  assign test_sel = par_mode ? 2'b00 : t_val;

  always_comb begin
    case (test_sel)
      2'b01:   test_out = ser_dat;
      2'b10:   test_out = fb_clk;
      2'b11:   test_out = syn_clk;
      default: test_out = 1'b0;
    endcase
  end
endmodule

// File: rtl/divcfg_loader_chk.sv
module divcfg_loader_chk #(
  parameter int MW = 9,
  parameter int NW = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pl_s,
  input logic                sld_s,
  input logic [MW-1:0]       m_s,
  input logic [MW+NW+2:0]    sr,
  input logic [MW-1:0]       m_val,
  input logic [1:0]          t_val,
  input logic [1:0]          test_sel,
  input logic                test_out,
  input logic                ser_dat,
  input logic                fb_clk,
  input logic                syn_clk
);
  p_par_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pl_s |=> m_val == $past(m_s));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_s && !sld_s) |=> ($stable(m_val) && $stable(t_val)));

  p_ser_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_s && sld_s) |=> m_val == sr[MW-1:0]);

  p_test_par_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pl_s |=> test_sel == 2'b00);

  p_par_keeps_t_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pl_s |=> $stable(t_val));

  always_comb begin
    if (rst_n) begin
      p_mux_r9: assert ((test_sel == 2'b00 && !test_out) || (test_sel == 2'b01 && test_out == ser_dat) ||
                        (test_sel == 2'b10 && test_out == fb_clk) || (test_sel == 2'b11 && test_out == syn_clk));
    end
  end
endmodule

bind divcfg_loader divcfg_loader_chk #(.MW(MW), .NW(NW)) u_chk (.*);

// File: tb/tb_divcfg_loader.sv
module tb_divcfg_loader;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       par_load, ser_clk, ser_dat, ser_strobe, fb_clk, syn_clk;
  logic [8:0] par_m, m_val;
  logic [1:0] par_n, n_val, t_val, test_sel;
  logic       test_out;
  logic [13:0] sr_m;
  int total = 0, fails = 0;

  always #2 clk = ~clk;

  divcfg_loader dut (.*);

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    ser_dat = b; cyc(3);
    ser_clk = 1'b1; cyc(4);
    ser_clk = 1'b0; cyc(3);
    sr_m = {sr_m[12:0], b};
  endtask

  task automatic shift_frame(input logic [1:0] t, input logic nul, input logic [1:0] n, input logic [8:0] m);
    logic [13:0] f;
    f = {t, nul, n, m};
    for (int i = 13; i >= 0; i--) shift_bit(f[i]);
  endtask

  task automatic strobe_pulse();
    ser_strobe = 1'b1; cyc(5);
    ser_strobe = 1'b0; cyc(5);
  endtask

  task automatic t_reset();
    chk("R1", "m", 16'(m_val), 0);
    chk("R1", "n", 16'(n_val), 0);
    chk("R1", "t", 16'(t_val), 0);
    chk("R1", "sel", 16'(test_sel), 0);
  endtask

  task automatic t_par_follow();
    par_load = 1'b0; par_m = 9'h19b; par_n = 2'd2; cyc(4);
    chk("R2", "m", 16'(m_val), 16'h19b);
    chk("R2", "n", 16'(n_val), 2);
    par_m = 9'h0a5; par_n = 2'd1; cyc(4);
    chk("R2", "m second", 16'(m_val), 16'h0a5);
    chk("R8", "sel par", 16'(test_sel), 0);
  endtask

  task automatic t_par_latch();
    par_m = 9'd28; par_n = 2'd1; cyc(4);
    par_load = 1'b1; cyc(4);
    par_m = 9'h1ff; par_n = 2'd3; cyc(6);
    chk("R3", "m held", 16'(m_val), 28);
    chk("R3", "n held", 16'(n_val), 1);
  endtask

  task automatic t_serial();
    shift_frame(2'b11, 1'b0, 2'd2, 9'd300);
    chk("R4", "m before strobe", 16'(m_val), 28);
    chk("R4", "t before strobe", 16'(t_val), 0);
    strobe_pulse();
    chk("R5", "m", 16'(m_val), 300);
    chk("R5", "n", 16'(n_val), 2);
    chk("R5", "t", 16'(t_val), 3);
    chk("R8", "sel serial", 16'(test_sel), 3);
    chk("R7", "override m", 16'(m_val), 300);
    shift_frame(2'b01, 1'b1, 2'd0, 9'd25);
    strobe_pulse();
    chk("R5", "null m", 16'(m_val), 25);
    chk("R5", "null n", 16'(n_val), 0);
    chk("R5", "null t", 16'(t_val), 1);
  endtask

  task automatic t_mux();
    fb_clk = 1'b0; syn_clk = 1'b0;
    ser_dat = 1'b1; #1 chk("R9", "sel01 hi", 16'(test_out), 1);
    ser_dat = 1'b0; #1 chk("R9", "sel01 lo", 16'(test_out), 0);
    shift_frame(2'b10, 1'b0, 2'd1, 9'd31); strobe_pulse();
    fb_clk = 1'b1; #1 chk("R9", "sel10 hi", 16'(test_out), 1);
    fb_clk = 1'b0; #1 chk("R9", "sel10 lo", 16'(test_out), 0);
    shift_frame(2'b11, 1'b0, 2'd1, 9'd31); strobe_pulse();
    syn_clk = 1'b1; #1 chk("R9", "sel11 hi", 16'(test_out), 1);
    shift_frame(2'b00, 1'b0, 2'd1, 9'd31); strobe_pulse();
    fb_clk = 1'b1; #1 chk("R9", "sel00", 16'(test_out), 0);
    syn_clk = 1'b0; fb_clk = 1'b0;
  endtask

  task automatic t_pass();
    shift_frame(2'b11, 1'b0, 2'd3, 9'd100);
    ser_strobe = 1'b1; cyc(5);
    chk("R6", "load", 16'(m_val), 100);
    shift_bit(1'b1);
    chk("R6", "pass 1", 16'(m_val), 16'(sr_m[8:0]));
    chk("R6", "pass 1 n", 16'(n_val), 16'(sr_m[10:9]));
    shift_bit(1'b0);
    chk("R6", "pass 2", 16'(m_val), 16'(sr_m[8:0]));
    shift_bit(1'b1);
    chk("R6", "pass 3 t", 16'(t_val), 16'(sr_m[13:12]));
    ser_strobe = 1'b0; cyc(5);
    begin
      logic [8:0] held = sr_m[8:0];
      shift_bit(1'b0); shift_bit(1'b1);
      chk("R6", "held after fall", 16'(m_val), 16'(held));
    end
  endtask

  task automatic t_par_return();
    logic [1:0] tk = t_val;
    par_m = 9'h055; par_n = 2'd3; par_load = 1'b0; cyc(4);
    chk("R7", "pins retake", 16'(m_val), 16'h055);
    chk("R10", "t kept", 16'(t_val), 16'(tk));
    chk("R8", "sel back to 0", 16'(test_sel), 0);
    par_load = 1'b1; cyc(4);
    shift_frame(2'b10, 1'b0, 2'd0, 9'd480); strobe_pulse();
    chk("R7", "serial over latch", 16'(m_val), 480);
  endtask

  initial begin
    #400000;
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst_n = 1'b0; par_load = 1'b0; par_m = '0; par_n = '0;
    ser_clk = 1'b0; ser_dat = 1'b0; ser_strobe = 1'b0; fb_clk = 1'b0; syn_clk = 1'b0;
    sr_m = '0;
    cyc(3);
    t_reset();
    rst_n = 1'b1; cyc(2);
    t_par_follow();
    t_par_latch();
    t_serial();
    t_mux();
    t_pass();
    t_par_return();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule